// File: doc/BRIEF.md
# Gated Cycle and Retired-Miss Counter Bank

This block sits beside a two-thread processor core and keeps a small bank of performance counters. Four of them count clock cycles, each under its own gating rule: a per-thread "busy" count for each logical thread, a single "awake" count for the whole physical core, and a single timestamp count. The fifth counter accumulates retired micro-ops that suffered a first-level cache miss. The retire stage supplies a sticky per-micro-op miss flag, so a micro-op that missed several times is still counted once.

Every counter is loadable through a one-port write interface and observable through a combinational read port. A separate output tells the surrounding logic when the monitoring counters may be powered down.

Top module: `cyc_gate_counters`

## Requirements
- R1: Counter 0 (thread-0 busy) adds one on each cycle in which `threadHalted[0]` and `threadPowerSave[0]` are both low.
- R2: Counter 1 (thread-1 busy) adds one on each cycle in which `dualThread` is high and `threadHalted[1]` and `threadPowerSave[1]` are both low. While `dualThread` is low, counter 1 holds, and the thread-1 inputs have no effect on any counter or on `monitorOff`.
- R3: Counter 2 (core awake) adds one on each cycle in which `sleepLevel` is 2'b00 (awake) and the core is not in power-save. The core counts as in power-save when every enabled thread has its power-save flag set: thread 0 alone in single-thread mode, both threads in dual-thread mode.
- R4: Counter 3 (timestamp) adds one on every cycle except those with `sleepLevel` 2'b11 (deep sleep). The codes 2'b01 (halt-sleep) and 2'b10 (light sleep) do not stop it.
- R5: Counter 4 (retired misses) adds, each cycle, the number of retire lanes with both `retireValid` and `retireMiss` set, at 0 to 2 per cycle.
- R6: `monitorOff` is combinational. In dual-thread mode it is high exactly when both threads are halted. In single-thread mode it follows `threadHalted[0]`.
- R7: All counters are 64 bits wide and wrap from all-ones to zero.
- R8: When `wrEn` is high, the counter chosen by `wrSel` (index 0 to 4 as above) takes `wrData` at the next clock edge. This replaces that cycle's increment, and the other counters still count normally.
- R9: `rdData` shows, in the same cycle, the registered value of the counter chosen by `rdSel`, so a write or increment in that cycle is not yet visible. A `rdSel` value of 5 to 7 reads zero.
- R10: A synchronous active-high `rst` clears all counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dualThread | input | 1 | Two-thread mode enable |
| threadHalted | input | 2 | Per-thread halted flag |
| threadPowerSave | input | 2 | Per-thread power-save flag |
| sleepLevel | input | 2 | Core sleep level: 00 awake, 01 halt-sleep, 10 light, 11 deep |
| retireValid | input | 2 | Per-lane micro-op retiring |
| retireMiss | input | 2 | Per-lane sticky first-level miss flag of the retiring micro-op |
| wrEn | input | 1 | Counter load strobe |
| wrSel | input | 3 | Counter index to load |
| wrData | input | 64 | Load value |
| rdSel | input | 3 | Counter index to read |
| rdData | output | 64 | Selected counter value |
| monitorOff | output | 1 | Counters may be powered down |

## Verification
A software load and the same counter's own increment can fall in the same cycle. The bench issues loads while the gating inputs would advance the target: the load must win, and the neighbouring counters must still advance. A read of the counter being loaded, sampled before the edge, must still show the old value. The bench sweeps every combination of halt, power-save, sleep level, mode and retire lanes, and compares all five counters with a running arithmetic model after every cycle.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
  localparam int NUM_CNT = 5;
  localparam int IDX_W = 3;
  localparam int RETIRE_LANES = 2;
  localparam int ADD_W = $clog2(RETIRE_LANES + 1);

  typedef enum logic [1:0] {
    SLP_AWAKE = 2'b00,
    SLP_HALT  = 2'b01,
    SLP_LIGHT = 2'b10,
    SLP_DEEP  = 2'b11
  } sleepLvl_e;

  localparam int IDX_BUSY0 = 0;
  localparam int IDX_BUSY1 = 1;
  localparam int IDX_AWAKE = 2;
  localparam int IDX_TSC   = 3;
  localparam int IDX_MISS  = 4;

  typedef struct packed {
    logic [NUM_CNT-1:0] incEn;
    logic [NUM_CNT-1:0] ldEn;
    logic [ADD_W-1:0]   missAdd;
  } cmonStrobe_t;
endpackage

// File: rtl/cmon_ctrl.sv
module cmon_ctrl
  import cmon_pkg::*;
(
  input  logic                    dualThread,
  input  logic [1:0]              threadHalted,
  input  logic [1:0]              threadPowerSave,
  input  logic [1:0]              sleepLevel,
  input  logic [RETIRE_LANES-1:0] retireValid,
  input  logic [RETIRE_LANES-1:0] retireMiss,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrSel,
  output cmonStrobe_t             strobe,
  output logic                    monitorOff
);
  sleepLvl_e slp;
  logic t0Busy, t1Busy, corePs;
  logic [ADD_W-1:0] missCnt;

  assign slp = sleepLvl_e'(sleepLevel);

  // thread 1 is masked out entirely in single-thread mode
  assign t0Busy = ~threadHalted[0] & ~threadPowerSave[0];
  assign t1Busy = dualThread & ~threadHalted[1] & ~threadPowerSave[1];
  assign corePs = dualThread ? (threadPowerSave[0] & threadPowerSave[1])
                             : threadPowerSave[0];
  assign monitorOff = dualThread ? (threadHalted[0] & threadHalted[1])
                                 : threadHalted[0];

  always_comb begin
    missCnt = '0;
    for (int l = 0; l < RETIRE_LANES; l++)
      missCnt = missCnt + ADD_W'(retireValid[l] & retireMiss[l]);
  end

  always_comb begin
    strobe = '0;
    strobe.incEn[IDX_BUSY0] = t0Busy;
    strobe.incEn[IDX_BUSY1] = t1Busy;
    strobe.incEn[IDX_AWAKE] = (slp == SLP_AWAKE) & ~corePs;
    strobe.incEn[IDX_TSC]   = (slp != SLP_DEEP);
    strobe.incEn[IDX_MISS]  = |missCnt;
    strobe.missAdd          = missCnt;
    for (int i = 0; i < NUM_CNT; i++)
      strobe.ldEn[i] = wrEn & (wrSel == IDX_W'(i));
  end

  always_comb begin
    a_ld_onehot_r8: assert ($onehot0(strobe.ldEn));
  end
endmodule

// File: rtl/cmon_counter.sv
module cmon_counter #(
  parameter int W = 64,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [W-1:0]      ldVal,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (ld)  value <= ldVal;
    else          value <= value + W'(step);
  end

  p_step_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !ld |=> value == $past(value) + W'($past(step)));
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ld |=> value == $past(ldVal));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> value == '0);
endmodule

// File: rtl/cmon_datapath.sv
module cmon_datapath
  import cmon_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cmonStrobe_t             strobe,
  input  logic [W-1:0]            wrData,
  input  logic [IDX_W-1:0]        rdSel,
  output logic [W-1:0]            rdData,
  output logic [NUM_CNT-1:0][W-1:0] cntAll
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [ADD_W-1:0] stepVal;
    if (i == IDX_MISS) begin : g_multi
      assign stepVal = strobe.missAdd;
    end else begin : g_single
      assign stepVal = ADD_W'(strobe.incEn[i]);
    end
    cmon_counter #(.W(W), .STEP_W(ADD_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .ld   (strobe.ldEn[i]),
      .ldVal(wrData),
      .step (stepVal),
      .value(cntAll[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rdSel == IDX_W'(i)) rdData = cntAll[i];
  end

  p_miss_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.ldEn[IDX_MISS] |=>
      (cntAll[IDX_MISS] - $past(cntAll[IDX_MISS])) <= W'(RETIRE_LANES));
endmodule

// File: rtl/cyc_gate_counters.sv
module cyc_gate_counters
  import cmon_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dualThread,
  input  logic [1:0]       threadHalted,
  input  logic [1:0]       threadPowerSave,
  input  logic [1:0]       sleepLevel,
  input  logic [1:0]       retireValid,
  input  logic [1:0]       retireMiss,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             monitorOff
);
  cmonStrobe_t strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntAll;

  cmon_ctrl u_ctrl (
    .dualThread     (dualThread),
    .threadHalted   (threadHalted),
    .threadPowerSave(threadPowerSave),
    .sleepLevel     (sleepLevel),
    .retireValid    (retireValid),
    .retireMiss     (retireMiss),
    .wrEn           (wrEn),
    .wrSel          (wrSel),
    .strobe         (strobe),
    .monitorOff     (monitorOff)
  );

  cmon_datapath #(.W(CNT_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .wrData(wrData),
    .rdSel (rdSel),
    .rdData(rdData),
    .cntAll(cntAll)
  );

  p_tsc_deep_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sleepLevel == 2'b11 && !(wrEn && wrSel == 3'd3))
      |=> cntAll[IDX_TSC] == $past(cntAll[IDX_TSC]));
  p_tsc_light_run_r4: assert property (@(posedge clk) disable iff (rst)
    (sleepLevel != 2'b11 && !(wrEn && wrSel == 3'd3))
      |=> cntAll[IDX_TSC] == $past(cntAll[IDX_TSC]) + 1'b1);
  p_busy1_single_r2: assert property (@(posedge clk) disable iff (rst)
    (!dualThread && !(wrEn && wrSel == 3'd1)) |=> $stable(cntAll[IDX_BUSY1]));
  p_awake_sleep_r3: assert property (@(posedge clk) disable iff (rst)
    (sleepLevel != 2'b00 && !(wrEn && wrSel == 3'd2)) |=> $stable(cntAll[IDX_AWAKE]));
  p_monoff_both_r6: assert property (@(posedge clk) disable iff (rst)
    (dualThread && !(threadHalted[0] && threadHalted[1])) |-> !monitorOff);
endmodule

// File: tb/tb_cyc_gate_counters.sv
`timescale 1ns/1ps
module tb_cyc_gate_counters;
  logic clk = 1'b0;
  logic rst;
  logic dualThread;
  logic [1:0] threadHalted, threadPowerSave, sleepLevel, retireValid, retireMiss;
  logic wrEn;
  logic [2:0] wrSel, rdSel;
  logic [63:0] wrData, rdData;
  logic monitorOff;

  int testsRun = 0;
  int testsFailed = 0;
  logic [63:0] expCnt [5];
  string reqTag [5] = '{"R1", "R2", "R3", "R4", "R5"};

  always #2.5 clk = ~clk;

  cyc_gate_counters dut (
    .clk(clk), .rst(rst), .dualThread(dualThread), .threadHalted(threadHalted),
    .threadPowerSave(threadPowerSave), .sleepLevel(sleepLevel),
    .retireValid(retireValid), .retireMiss(retireMiss), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .monitorOff(monitorOff)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string extra);
    for (int k = 0; k < 5; k++) begin
      rdSel = 3'(k);
      #0.2;
      check({reqTag[k], extra}, rdData, expCnt[k]);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic runCycle(input logic dl, input logic [1:0] h, ps, slp, rv, rm,
                          input logic we, input logic [2:0] ws, input logic [63:0] wd);
    logic physPs;
    dualThread = dl; threadHalted = h; threadPowerSave = ps; sleepLevel = slp;
    retireValid = rv; retireMiss = rm; wrEn = we; wrSel = ws; wrData = wd;
    #0.5;
    check("R6 monitorOff", 64'(monitorOff), 64'(dl ? (h[0] & h[1]) : h[0]));
    @(posedge clk);
    physPs = dl ? (ps[0] & ps[1]) : ps[0];
    if (!h[0] && !ps[0]) expCnt[0] += 1;              // R1
    if (dl && !h[1] && !ps[1]) expCnt[1] += 1;        // R2
    if (slp == 2'b00 && !physPs) expCnt[2] += 1;      // R3
    if (slp != 2'b11) expCnt[3] += 1;                 // R4
    expCnt[4] += 64'(rv[0] & rm[0]) + 64'(rv[1] & rm[1]); // R5
    if (we && ws < 3'd5) expCnt[ws] = wd;             // R8
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1; dualThread = 0; threadHalted = 0; threadPowerSave = 0;
    sleepLevel = 0; retireValid = 0; retireMiss = 0; wrEn = 0; wrSel = 0;
    wrData = 0; rdSel = 0;
    for (int k = 0; k < 5; k++) expCnt[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkAll(" R10 reset state");

    // exhaustive sweep of gating inputs and retire lanes
    for (int c = 0; c < 2048; c++) begin
      logic [10:0] v;
      v = 11'(c);
      runCycle(v[6], v[1:0], v[3:2], v[5:4], v[8:7], v[10:9], 1'b0, 3'd0, 64'd0);
      checkAll(" sweep");
    end

    // load collides with increment; read still shows old value (R8, R9)
    dualThread = 1; threadHalted = 0; threadPowerSave = 0; sleepLevel = 0;
    wrEn = 1; wrSel = 3'd3; wrData = 64'h1234_5678_9ABC_DEF0; rdSel = 3'd3;
    #0.3;
    check("R9 pre-edge read", rdData, expCnt[3]);
    runCycle(1, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 1, 3'd3, 64'h1234_5678_9ABC_DEF0);
    checkAll(" R8 load wins");
    runCycle(1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1, 3'd0, 64'hAAAA_0000_5555_FFFF);
    checkAll(" R8 load busy0");

    // wrap to zero (R7)
    runCycle(1, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 1, 3'd3, '1);
    runCycle(1, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 0, 3'd0, 64'd0);
    check("R7 tsc wrap", expCnt[3], 64'd0);
    checkAll(" R7 wrap");
    runCycle(1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFE);
    runCycle(1, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 0, 3'd0, 64'd0);
    checkAll(" R7 miss wrap");

    // out-of-range read and ignored out-of-range write (R9)
    runCycle(0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1, 3'd6, 64'hDEAD);
    checkAll(" R9 bad write index");
    for (int s = 5; s < 8; s++) begin
      rdSel = 3'(s);
      #0.2;
      check("R9 unmapped read", rdData, 64'd0);
    end

    // synchronous reset mid-run (R10)
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) expCnt[k] = '0;
    checkAll(" R10 mid-run reset");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule